// File: doc/BRIEF.md
# Reader Power-Mode and Startup Sequencer

This block owns the power state of a contactless reader core. A hard power-down pin or a power-on-reset input pushes it into an off phase at any time. Once both are released, the oscillator reports stable and a minimum off time has passed, it runs a fixed-length register-preset phase and then a fixed-length initialising phase. After that it raises its ready flag. The minimum off time is derived from the oscillator frequency parameter and equals 100 µs of oscillator cycles. Both the pin and the power-on-reset input are assumed to arrive already synchronised to the oscillator clock.

Once ready, software controls two bits through a one-cycle write strobe. The sleep bit gates the internal digital clock. Entry takes effect on the next cycle. Exit takes four oscillator cycles after software writes the bit back to 0, and the bit keeps reading 1 until the exit has completed. The receiver auto-power-down bit decides whether receiver power follows the receiver-busy flag or stays on. While sleeping, the block holds its outputs.

Top module: `rdr_pwr_seq`

## Requirements
- R1: When pwr_off_i or por_i is 1 at a clock edge, from the next cycle on ready_o, preset_o, dclk_en_o and rx_pwr_en_o are all 0. This holds from any phase, including sleep and the middle of the preset count, and the following startup runs its full lengths again.
- R2: The off phase lasts max(P, MIN_PD, S) cycles, counted from the first edge at which an off input is seen. P is the number of edges the off input stays high, S is the number of edges until osc_stable_i is 1, and MIN_PD = ceil(OSC_KHZ*PD_MIN_US/1000).
- R3: The preset phase starts only with osc_stable_i at 1. In it, preset_o is 1 for exactly RST_CYC consecutive cycles. It reloads the sleep bit to 0 and the auto-power-down bit to RXAUTO_RST, and dclk_en_o is 1 throughout.
- R4: The initialising phase follows the preset phase for exactly INIT_CYC cycles. In it, dclk_en_o is 1, ready_o is 0 and preset_o is 0. ready_o rises at the end of the phase.
- R5: In the ready state, a write (wr_en_i=1) with wr_sleep_i=1 sets sleep_o to 1 and dclk_en_o to 0 in the very next cycle. ready_o stays 1.
- R6: In sleep, a write with wr_sleep_i=0 leaves sleep_o at 1 and dclk_en_o at 0 for exactly four more cycles. After that, sleep_o is 0 and dclk_en_o is 1.
- R7: In the ready state, rx_pwr_en_o is one cycle after its inputs equal (rxauto_o==0) OR rx_busy_i. Before ready is reached, rx_pwr_en_o is 0.
- R8: In sleep and during its exit, rx_pwr_en_o holds its value whatever rx_busy_i does. Writes to the auto-power-down bit are ignored there, and so is a write with wr_sleep_i=1.
- R9: Writes issued before the ready state (preset or initialising phase) have no effect: sleep_o, rxauto_o and dclk_en_o are unchanged when ready is reached.
- R10: While rst_n_i is 0, all outputs are 0 (with RXAUTO_RST=0) and the block sits in the off phase. Assertion of rst_n_i takes effect without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Oscillator clock, keeps running in sleep |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_off_i | input | 1 | Hard power-down pin, 1 = off |
| por_i | input | 1 | Power-on-reset indication, 1 = off |
| osc_stable_i | input | 1 | Oscillator stable flag |
| wr_en_i | input | 1 | One-cycle write strobe for the control bits |
| wr_sleep_i | input | 1 | Sleep bit value written with wr_en_i |
| wr_rxauto_i | input | 1 | Receiver auto-power-down bit value written with wr_en_i |
| rx_busy_i | input | 1 | Receiver in use |
| preset_o | output | 1 | Register preset strobe, high through the preset phase |
| dclk_en_o | output | 1 | Internal digital clock enable |
| rx_pwr_en_o | output | 1 | Receiver power enable |
| ready_o | output | 1 | Startup finished |
| sleep_o | output | 1 | Read value of the sleep bit |
| rxauto_o | output | 1 | Read value of the auto-power-down bit |

## Verification
The bench builds the block with OSC_KHZ=80, which gives an 8-cycle minimum off time, and with INIT_CYC=16. RST_CYC stays at its default of 512. The short minimum lets off pulses from 1 to 12 cycles be swept across the stretch boundary, with late oscillator-stable cases mixed in, while every startup still runs the full 512-cycle preset count. Sleep is entered and left with several dwell lengths. Each exit is checked cycle by cycle, and the receiver enable is swept over both auto-power-down settings and both busy values, inside and outside sleep.

// File: rtl/rdr_pwr_pkg.sv
package rdr_pwr_pkg;

  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_PRESET = 3'd1,
    PH_INIT   = 3'd2,
    PH_RUN    = 3'd3,
    PH_SLEEP  = 3'd4,
    PH_WAKE   = 3'd5
  } phase_e;

  // Sleep exit delay in oscillator cycles
  localparam int unsigned WAKE_CYC = 4;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rdr_pwr_pdq.sv
// Off-phase qualifier: counts cycles spent in the off phase, saturating.
module rdr_pwr_pdq #(
  parameter int unsigned MIN_PD = 1356
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_off,
  output logic pd_met
);

  localparam int unsigned CW = (MIN_PD < 2) ? 1 : $clog2(MIN_PD);
  localparam logic [CW-1:0] LAST = CW'(MIN_PD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!in_off) begin
      cnt_d = '0;
    end else if (cnt_q != LAST) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign pd_met = (cnt_q == LAST);

endmodule

// File: rtl/rdr_pwr_timer.sv
// Shared phase counter for preset, initialising and wake phases.
module rdr_pwr_timer
  import rdr_pwr_pkg::*;
#(
  parameter int unsigned RST_CYC  = 512,
  parameter int unsigned INIT_CYC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic rst_last,
  output logic init_last,
  output logic wake_last
);

  localparam int unsigned MAXC = max3(RST_CYC, INIT_CYC, WAKE_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned NLIM = 3;
  localparam int unsigned LIMS [NLIM] = '{RST_CYC, INIT_CYC, WAKE_CYC};

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [NLIM-1:0] hit;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    assign hit[g] = (cnt_q == CW'(LIMS[g] - 1));
  end

  assign rst_last  = hit[0];
  assign init_last = hit[1];
  assign wake_last = hit[2];

endmodule

// File: rtl/rdr_pwr_fsm.sv
// Phase sequencer: off, preset, initialising, run, sleep, wake.
module rdr_pwr_fsm
  import rdr_pwr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   off_req,
  input  logic   osc_ok,
  input  logic   pd_met,
  input  logic   wr_en,
  input  logic   wr_sleep,
  input  logic   rst_last,
  input  logic   init_last,
  input  logic   wake_last,
  output phase_e phase_q,
  output logic   cnt_clr,
  output logic   cnt_en,
  output logic   sleep_set,
  output logic   sleep_clr
);

  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_OFF:    if (pd_met && osc_ok)     phase_d = PH_PRESET;
      PH_PRESET: if (rst_last)             phase_d = PH_INIT;
      PH_INIT:   if (init_last)            phase_d = PH_RUN;
      PH_RUN:    if (wr_en && wr_sleep)    phase_d = PH_SLEEP;
      PH_SLEEP:  if (wr_en && !wr_sleep)   phase_d = PH_WAKE;
      PH_WAKE:   if (wake_last)            phase_d = PH_RUN;
      default:                             phase_d = PH_OFF;
    endcase
    // Power-down overrides every phase
    if (off_req) begin
      phase_d = PH_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign cnt_clr   = (phase_d != phase_q);
  assign cnt_en    = (phase_q == PH_PRESET) || (phase_q == PH_INIT) || (phase_q == PH_WAKE);
  assign sleep_set = (phase_q == PH_RUN)  && (phase_d == PH_SLEEP);
  assign sleep_clr = (phase_q == PH_WAKE) && (phase_d == PH_RUN);

endmodule

// File: rtl/rdr_pwr_regs.sv
// Control bits and the held receiver-power output.
module rdr_pwr_regs
  import rdr_pwr_pkg::*;
#(
  parameter logic RXAUTO_RST = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   off_req,
  input  logic   wr_en,
  input  logic   wr_rxauto,
  input  logic   rx_busy,
  input  logic   sleep_set,
  input  logic   sleep_clr,
  output logic   sleep_q,
  output logic   rxauto_q,
  output logic   rx_pwr_q
);

  logic sleep_d, rxauto_d, rx_pwr_d;
  logic in_run, in_hold;

  assign in_run  = (phase == PH_RUN);
  assign in_hold = (phase == PH_SLEEP) || (phase == PH_WAKE);

  always_comb begin
    sleep_d = sleep_q;
    if (phase == PH_PRESET) begin
      sleep_d = 1'b0;
    end else if (sleep_set) begin
      sleep_d = 1'b1;
    end else if (sleep_clr) begin
      sleep_d = 1'b0;
    end
  end

  always_comb begin
    rxauto_d = rxauto_q;
    if (phase == PH_PRESET) begin
      rxauto_d = RXAUTO_RST;
    end else if (in_run && wr_en && !off_req) begin
      rxauto_d = wr_rxauto;
    end
  end

  always_comb begin
    rx_pwr_d = rx_pwr_q;
    if (off_req || !(in_run || in_hold)) begin
      rx_pwr_d = 1'b0;
    end else if (in_run) begin
      rx_pwr_d = !rxauto_q || rx_busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q  <= 1'b0;
      rxauto_q <= RXAUTO_RST;
      rx_pwr_q <= 1'b0;
    end else begin
      sleep_q  <= sleep_d;
      rxauto_q <= rxauto_d;
      rx_pwr_q <= rx_pwr_d;
    end
  end

endmodule

// File: rtl/rdr_pwr_seq.sv
// Power-mode and startup sequencer top.
module rdr_pwr_seq
  import rdr_pwr_pkg::*;
#(
  parameter int unsigned OSC_KHZ     = 13560,
  parameter int unsigned PD_MIN_US   = 100,
  parameter int unsigned RST_CYC     = 512,
  parameter int unsigned INIT_CYC    = 128,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        RXAUTO_RST  = 1'b0
) (
  input  logic clk_osc_i,
  input  logic rst_n_i,
  input  logic pwr_off_i,
  input  logic por_i,
  input  logic osc_stable_i,
  input  logic wr_en_i,
  input  logic wr_sleep_i,
  input  logic wr_rxauto_i,
  input  logic rx_busy_i,
  output logic preset_o,
  output logic dclk_en_o,
  output logic rx_pwr_en_o,
  output logic ready_o,
  output logic sleep_o,
  output logic rxauto_o
);

  localparam int unsigned PD_RAW = (OSC_KHZ * PD_MIN_US + 999) / 1000;
  localparam int unsigned MIN_PD = (PD_RAW < 1) ? 1 : PD_RAW;

  logic [SYNC_STAGES-1:0] rsync_q;
  logic   rst_n;
  logic   off_req, pd_met;
  logic   rst_last, init_last, wake_last;
  logic   cnt_clr, cnt_en, sleep_set, sleep_clr;
  phase_e phase;

  // Reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk_osc_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n = rsync_q[SYNC_STAGES-1];

  assign off_req = pwr_off_i || por_i;

  rdr_pwr_pdq #(.MIN_PD(MIN_PD)) u_pdq (
    .clk    (clk_osc_i),
    .rst_n  (rst_n),
    .in_off (phase == PH_OFF),
    .pd_met (pd_met)
  );

  rdr_pwr_timer #(.RST_CYC(RST_CYC), .INIT_CYC(INIT_CYC)) u_timer (
    .clk       (clk_osc_i),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .en        (cnt_en),
    .rst_last  (rst_last),
    .init_last (init_last),
    .wake_last (wake_last)
  );

  rdr_pwr_fsm u_fsm (
    .clk       (clk_osc_i),
    .rst_n     (rst_n),
    .off_req   (off_req),
    .osc_ok    (osc_stable_i),
    .pd_met    (pd_met),
    .wr_en     (wr_en_i),
    .wr_sleep  (wr_sleep_i),
    .rst_last  (rst_last),
    .init_last (init_last),
    .wake_last (wake_last),
    .phase_q   (phase),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en),
    .sleep_set (sleep_set),
    .sleep_clr (sleep_clr)
  );

  rdr_pwr_regs #(.RXAUTO_RST(RXAUTO_RST)) u_regs (
    .clk       (clk_osc_i),
    .rst_n     (rst_n),
    .phase     (phase),
    .off_req   (off_req),
    .wr_en     (wr_en_i),
    .wr_rxauto (wr_rxauto_i),
    .rx_busy   (rx_busy_i),
    .sleep_set (sleep_set),
    .sleep_clr (sleep_clr),
    .sleep_q   (sleep_o),
    .rxauto_q  (rxauto_o),
    .rx_pwr_q  (rx_pwr_en_o)
  );

  assign preset_o  = (phase == PH_PRESET);
  assign dclk_en_o = (phase == PH_PRESET) || (phase == PH_INIT) || (phase == PH_RUN);
  assign ready_o   = (phase == PH_RUN) || (phase == PH_SLEEP) || (phase == PH_WAKE);

endmodule

// File: rtl/rdr_pwr_seq_chk.sv
module rdr_pwr_seq_chk (
  input logic clk_osc_i,
  input logic rst_n_i,
  input logic pwr_off_i,
  input logic por_i,
  input logic osc_stable_i,
  input logic wr_en_i,
  input logic wr_sleep_i,
  input logic wr_rxauto_i,
  input logic rx_busy_i,
  input logic preset_o,
  input logic dclk_en_o,
  input logic rx_pwr_en_o,
  input logic ready_o,
  input logic sleep_o,
  input logic rxauto_o
);

  assert_off_forces_idle_R1: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    (pwr_off_i || por_i) |=> (!ready_o && !preset_o && !dclk_en_o && !rx_pwr_en_o));

  assert_preset_after_osc_R3: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    $rose(preset_o) |-> $past(osc_stable_i));

  assert_sleep_entry_R5: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    (ready_o && dclk_en_o && wr_en_i && wr_sleep_i && !pwr_off_i && !por_i)
      |=> (!dclk_en_o && sleep_o && ready_o));

  assert_sleep_clears_with_clock_R6: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    $fell(sleep_o) |-> dclk_en_o);

  assert_rx_follows_busy_R7: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    (ready_o && dclk_en_o && $past(ready_o && dclk_en_o) && !$past(pwr_off_i || por_i))
      |-> (rx_pwr_en_o == (!$past(rxauto_o) || $past(rx_busy_i))));

  assert_rx_held_in_sleep_R8: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    (ready_o && !dclk_en_o && $past(ready_o && !dclk_en_o) && !$past(pwr_off_i || por_i))
      |-> $stable(rx_pwr_en_o));

  assert_rxauto_write_only_R9: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    (!$stable(rxauto_o) && !$past(preset_o))
      |-> ($past(ready_o && dclk_en_o && wr_en_i) && (rxauto_o == $past(wr_rxauto_i))));

endmodule

bind rdr_pwr_seq rdr_pwr_seq_chk i_chk (.*);

// File: tb/test_rdr_pwr_seq.sv
module test_rdr_pwr_seq;

  localparam int T_KHZ   = 80;
  localparam int T_RST   = 512;
  localparam int T_INIT  = 16;
  localparam int T_MINPD = (T_KHZ * 100 + 999) / 1000;

  logic clk_osc_i = 1'b0;
  always #2.5 clk_osc_i = ~clk_osc_i;

  logic rst_n_i, pwr_off_i, por_i, osc_stable_i;
  logic wr_en_i, wr_sleep_i, wr_rxauto_i, rx_busy_i;
  logic preset_o, dclk_en_o, rx_pwr_en_o, ready_o, sleep_o, rxauto_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  rdr_pwr_seq #(
    .OSC_KHZ(T_KHZ), .RST_CYC(T_RST), .INIT_CYC(T_INIT), .RXAUTO_RST(1'b0)
  ) i_rdr_pwr_seq (
    .clk_osc_i(clk_osc_i), .rst_n_i(rst_n_i), .pwr_off_i(pwr_off_i), .por_i(por_i),
    .osc_stable_i(osc_stable_i), .wr_en_i(wr_en_i), .wr_sleep_i(wr_sleep_i),
    .wr_rxauto_i(wr_rxauto_i), .rx_busy_i(rx_busy_i), .preset_o(preset_o),
    .dclk_en_o(dclk_en_o), .rx_pwr_en_o(rx_pwr_en_o), .ready_o(ready_o),
    .sleep_o(sleep_o), .rxauto_o(rxauto_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_osc_i);
  endtask

  task automatic wr(input logic s, input logic a);
    wr_sleep_i = s; wr_rxauto_i = a; wr_en_i = 1'b1;
    step();
    wr_en_i = 1'b0;
  endtask

  // Called at a negedge. Pulses an off input for p edges, raises osc_stable
  // at edge osc_at (0: already stable), then measures every phase.
  task automatic startup(input int p, input int osc_at, input bit use_por,
                         input bit poke, input int stop_pre);
    int d_exp, n_off, n_pre, n_init, k;
    d_exp = p;
    if (T_MINPD > d_exp) d_exp = T_MINPD;
    if (osc_at > d_exp)  d_exp = osc_at;
    if (osc_at > 0) osc_stable_i = 1'b0;
    if (use_por) por_i = 1'b1; else pwr_off_i = 1'b1;
    n_off = 0;
    k = 0;
    forever begin
      step();
      k++;
      if (k == 1) begin
        chk("R1 ready after off", int'(ready_o), 0);
        chk("R1 preset after off", int'(preset_o), 0);
        chk("R1 dclk after off", int'(dclk_en_o), 0);
        chk("R1 rx power after off", int'(rx_pwr_en_o), 0);
      end
      if (preset_o || k > 5000) break;
      n_off++;
      if (k == p) begin pwr_off_i = 1'b0; por_i = 1'b0; end
      if (k == osc_at) osc_stable_i = 1'b1;
    end
    chk($sformatf("R2 off length p=%0d osc=%0d", p, osc_at), n_off, d_exp);
    n_pre = 0;
    while (preset_o) begin
      n_pre++;
      if (!dclk_en_o) chk("R3 dclk in preset", 0, 1);
      if (stop_pre != 0 && n_pre == stop_pre) return;
      wr_sleep_i = 1'b1; wr_rxauto_i = 1'b1;
      wr_en_i = poke && (n_pre == 3);
      step();
      wr_en_i = 1'b0;
    end
    chk("R3 preset length", n_pre, T_RST);
    chk("R3 sleep preset", int'(sleep_o), 0);
    chk("R3 rxauto preset", int'(rxauto_o), 0);
    n_init = 0;
    while (!ready_o && n_init < 1000) begin
      if (!dclk_en_o || preset_o) chk("R4 init outputs", 0, 1);
      if (rx_pwr_en_o) chk("R7 rx off before ready", 1, 0);
      n_init++;
      wr_en_i = poke && (n_init == 2);
      step();
      wr_en_i = 1'b0;
    end
    wr_sleep_i = 1'b0; wr_rxauto_i = 1'b0;
    chk("R4 init length", n_init, T_INIT);
    chk("R4 ready", int'(ready_o), 1);
    if (poke) begin
      chk("R9 sleep after early write", int'(sleep_o), 0);
      chk("R9 rxauto after early write", int'(rxauto_o), 0);
      chk("R9 dclk after early write", int'(dclk_en_o), 1);
    end
  endtask

  task automatic sleep_cycle(input int hold, input logic a);
    wr(1'b1, a);
    chk("R5 dclk off", int'(dclk_en_o), 0);
    chk("R5 sleep bit", int'(sleep_o), 1);
    chk("R5 ready held", int'(ready_o), 1);
    repeat (hold) step();
    chk("R5 still asleep", int'(sleep_o & ~dclk_en_o), 1);
    wr(1'b0, a);
    for (int i = 0; i < 4; i++) begin
      chk($sformatf("R6 exit cycle %0d sleep", i), int'(sleep_o), 1);
      chk($sformatf("R6 exit cycle %0d dclk", i), int'(dclk_en_o), 0);
      step();
    end
    chk("R6 sleep cleared", int'(sleep_o), 0);
    chk("R6 dclk back", int'(dclk_en_o), 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_osc_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R4 watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n_i = 1'b0; pwr_off_i = 1'b0; por_i = 1'b0; osc_stable_i = 1'b1;
    wr_en_i = 1'b0; wr_sleep_i = 1'b0; wr_rxauto_i = 1'b0; rx_busy_i = 1'b0;
    repeat (3) step();
    // R10 reset state
    chk("R10 ready", int'(ready_o), 0);
    chk("R10 preset", int'(preset_o), 0);
    chk("R10 dclk", int'(dclk_en_o), 0);
    chk("R10 rx", int'(rx_pwr_en_o), 0);
    chk("R10 sleep", int'(sleep_o), 0);
    chk("R10 rxauto", int'(rxauto_o), 0);
    rst_n_i = 1'b1;
    repeat (5) step();
    startup(20, 0, 1'b0, 1'b0, 0);

    // R2 pulse-width sweep across the minimum
    for (int p = 1; p <= 12; p++) startup(p, 0, p[0], 1'b0, 0);
    // R2/R3 late oscillator
    startup(3, 15, 1'b0, 1'b0, 0);
    startup(10, 21, 1'b1, 1'b0, 0);
    // R9 writes before ready
    startup(4, 0, 1'b0, 1'b1, 0);

    // R5/R6 sleep entry and exit with several dwell lengths
    for (int h = 0; h < 6; h++) sleep_cycle(h, 1'b0);

    // R7 receiver power sweep
    for (int a = 0; a < 2; a++) begin
      wr(1'b0, a[0]); step();
      chk("R7 rxauto written", int'(rxauto_o), a);
      for (int b = 0; b < 2; b++) begin
        rx_busy_i = b[0];
        step();
        chk($sformatf("R7 rx auto=%0d busy=%0d", a, b), int'(rx_pwr_en_o),
            ((a == 0) || (b == 1)) ? 1 : 0);
      end
    end

    // R8 hold in sleep; auto bit 1 and busy 1 give power on
    rx_busy_i = 1'b1; step();
    chk("R8 rx before sleep", int'(rx_pwr_en_o), 1);
    wr(1'b1, 1'b1);
    rx_busy_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i == 2) wr(1'b1, 1'b0); else step();
      chk("R8 rx held in sleep", int'(rx_pwr_en_o), 1);
      chk("R8 still asleep", int'(sleep_o), 1);
    end
    wr(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      chk("R8 rx held in exit", int'(rx_pwr_en_o), 1);
      chk("R8 exit sleep bit", int'(sleep_o), 1);
      step();
    end
    chk("R8 exit done", int'(sleep_o), 0);
    chk("R8 rxauto write ignored", int'(rxauto_o), 1);
    step();
    chk("R7 rx after wake", int'(rx_pwr_en_o), 0);

    // R1 power-down during sleep
    wr(1'b1, 1'b1);
    repeat (3) step();
    startup(5, 0, 1'b1, 1'b0, 0);
    chk("R1 sleep bit after restart", int'(sleep_o), 0);

    // R1 power-down in the middle of the preset count
    startup(6, 0, 1'b0, 1'b0, 200);
    startup(2, 0, 1'b0, 1'b0, 0);

    // R10 asynchronous reset from ready
    rst_n_i = 1'b0;
    #1;
    chk("R10 async ready", int'(ready_o), 0);
    chk("R10 async dclk", int'(dclk_en_o), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule